// File: doc/BRIEF.md
# SEC-DED Codec with Odd-Weight Check Columns

This block protects a data word with a single-error-correcting, double-error-detecting linear code. The encode side is purely combinational. It takes K data bits and returns an N = K + R bit code word. The data bits sit in the low positions and are unchanged. The R check bits sit above them. Each check bit is the XOR of the data bits that its row of the parity-check matrix selects. The check bits have identity columns. Every data column is a distinct R-bit value of odd weight of at least three. The columns are chosen lowest weight first, so the XOR trees stay as shallow as the code allows. The default is K = 4, R = 4, an (8,4) code. Setting K = 64, R = 8 gives a shortened (72,64) code. That code uses all 56 weight-three columns and then the 8 smallest weight-five columns.

The decode side accepts a received code word on a valid/ready stream. It recomputes the syndrome. If the syndrome equals the column of one bit, it flips that bit. It also classifies the word. A zero syndrome means a clean word. A nonzero syndrome of odd weight means a single error. A nonzero syndrome of even weight means a double error, because any two odd-weight columns sum to an even-weight value. The result sits in one register stage.

The output stage follows the usual valid/ready rules. The input is accepted on a cycle where both dec_valid_i and dec_ready_o are high. dec_ready_o is high whenever the output register is empty or is being drained in the same cycle. While dec_valid_o is high and dec_ready_i is low, the output holds its values.

Top module: `secded_codec`

## Requirements
- R1: enc_code_o[K-1:0] equals enc_data_i, and check bit i (enc_code_o[K+i]) is the XOR of the data bits whose column has bit i set. For the default code the data columns d0..d3 are 0111, 1011, 1101, 1110 (bit i of a column is row i). This gives c0=d0^d1^d2, c1=d0^d1^d3, c2=d0^d2^d3 and c3=d1^d2^d3.
- R2: A received word with zero syndrome decodes to its own data bits, with dec_sec_o=0 and dec_ded_o=0.
- R3: A word with exactly one flipped data bit decodes to the original data, with dec_sec_o=1 and dec_ded_o=0.
- R4: A word with exactly one flipped check bit decodes to unchanged data, with dec_sec_o=1 and dec_ded_o=0.
- R5: A word with exactly two flipped bits gives dec_ded_o=1 and dec_sec_o=0. dec_data_o then carries the received data bits with no correction.
- R6: dec_sec_o and dec_ded_o are never both high while dec_valid_o is high.
- R7: A word accepted at a clock edge appears with dec_valid_o=1 right after that edge. dec_ready_o is high exactly when the output register is empty or dec_ready_i is high.
- R8: While dec_valid_o=1 and dec_ready_i=0, dec_valid_o, dec_data_o, dec_sec_o and dec_ded_o hold their values.
- R9: While rst_n is low and after its release, dec_valid_o is 0 until a word is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_data_i | input | K | Data word to encode |
| enc_code_o | output | K+R | Code word: data low, check bits high |
| dec_valid_i | input | 1 | Received word valid |
| dec_ready_o | output | 1 | Decoder can accept a word |
| dec_code_i | input | K+R | Received code word |
| dec_valid_o | output | 1 | Decoded result valid |
| dec_ready_i | input | 1 | Consumer takes the result |
| dec_data_o | output | K | Corrected data |
| dec_sec_o | output | 1 | Single error seen and corrected |
| dec_ded_o | output | 1 | Double error detected, not corrected |

## Verification
Some properties are checked on every cycle:
- the two status flags never coexist;
- a stalled result stays frozen;
- an accepted word always shows up one edge later;
- any word that is fed straight back from the encoder decodes clean, carrying the data that was encoded.

The bench scenarios cover what no single-cycle property can show. They run the full encode table, every single-bit error position in data and check bits across all data values, and every two-bit error pair. This confirms which bit gets flipped and that double errors leave the data uncorrected, also under irregular back-pressure.

// File: rtl/secded_pkg.sv
package secded_pkg;

  localparam int unsigned MAX_W = 128;

  function automatic int unsigned popcnt(logic [31:0] v);
    int unsigned n;
    n = 0;
    for (int b = 0; b < 32; b++) n += int'(v[b]);
    return n;
  endfunction

  // Column of data bit idx: odd-weight (>=3) values, by weight then value
  function automatic logic [31:0] data_col(int r, int idx);
    logic [31:0] res;
    int          seen;
    bit          found;
    res   = '0;
    seen  = 0;
    found = 1'b0;
    for (int w = 3; w <= r; w += 2) begin
      for (int v = 1; v < (1 << r); v++) begin
        if (!found && popcnt(32'(v)) == w) begin
          if (seen == idx) begin
            res   = 32'(v);
            found = 1'b1;
          end
          seen++;
        end
      end
    end
    return res;
  endfunction

  // Data bits feeding check row `row`
  function automatic logic [MAX_W-1:0] row_mask(int r, int k, int row);
    logic [MAX_W-1:0] m;
    logic [31:0]      c;
    m = '0;
    for (int j = 0; j < k; j++) begin
      c = data_col(r, j);
      m[j] = c[row];
    end
    return m;
  endfunction

endpackage

// File: rtl/secded_parity.sv
module secded_parity
  import secded_pkg::*;
#(
  parameter int K = 4,
  parameter int R = 4
) (
  input  logic [K-1:0] data_i,
  output logic [R-1:0] par_o
);
  for (genvar i = 0; i < R; i++) begin : g_row
    localparam logic [MAX_W-1:0] FULL = row_mask(R, K, i);
    localparam logic [K-1:0]     MASK = FULL[K-1:0];
    assign par_o[i] = ^(data_i & MASK);
  end
endmodule

// File: rtl/secded_corrector.sv
module secded_corrector
  import secded_pkg::*;
#(
  parameter int K = 4,
  parameter int R = 4
) (
  input  logic [R-1:0] syn_i,
  input  logic [K-1:0] rx_data_i,
  output logic [K-1:0] fix_data_o,
  output logic         sec_o,
  output logic         ded_o
);
  logic [K-1:0] flip;
  logic         nonzero;
  logic         odd;

  for (genvar j = 0; j < K; j++) begin : g_bit
    localparam logic [31:0]  FULL = data_col(R, j);
    localparam logic [R-1:0] COL  = FULL[R-1:0];
    assign flip[j] = (syn_i == COL);
  end

  assign nonzero    = |syn_i;
  assign odd        = ^syn_i;
  assign fix_data_o = rx_data_i ^ flip;
  assign sec_o      = nonzero & odd;
  assign ded_o      = nonzero & ~odd;
endmodule

// File: rtl/secded_codec.sv
module secded_codec #(
  parameter int K = 4,
  parameter int R = 4,
  localparam int N = K + R
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [K-1:0] enc_data_i,
  output logic [N-1:0] enc_code_o,
  input  logic         dec_valid_i,
  output logic         dec_ready_o,
  input  logic [N-1:0] dec_code_i,
  output logic         dec_valid_o,
  input  logic         dec_ready_i,
  output logic [K-1:0] dec_data_o,
  output logic         dec_sec_o,
  output logic         dec_ded_o
);
  // Encode path
  logic [R-1:0] enc_chk;

  secded_parity #(.K(K), .R(R)) u_enc_par (
    .data_i (enc_data_i),
    .par_o  (enc_chk)
  );

  assign enc_code_o = {enc_chk, enc_data_i};

  // Decode path
  logic [R-1:0] rx_par;
  logic [R-1:0] syn;
  logic [K-1:0] fix_data;
  logic         fix_sec;
  logic         fix_ded;

  secded_parity #(.K(K), .R(R)) u_dec_par (
    .data_i (dec_code_i[K-1:0]),
    .par_o  (rx_par)
  );

  assign syn = rx_par ^ dec_code_i[N-1:K];

  secded_corrector #(.K(K), .R(R)) u_fix (
    .syn_i      (syn),
    .rx_data_i  (dec_code_i[K-1:0]),
    .fix_data_o (fix_data),
    .sec_o      (fix_sec),
    .ded_o      (fix_ded)
  );

  // Output register stage
  logic         out_v;
  logic [K-1:0] out_data;
  logic         out_sec;
  logic         out_ded;
  logic         take;

  assign dec_ready_o = !out_v || dec_ready_i;
  assign take        = dec_valid_i && dec_ready_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_v    <= 1'b0;
      out_data <= '0;
      out_sec  <= 1'b0;
      out_ded  <= 1'b0;
    end else begin
      if (dec_ready_o) out_v <= dec_valid_i;
      if (take) begin
        out_data <= fix_data;
        out_sec  <= fix_sec;
        out_ded  <= fix_ded;
      end
    end
  end

  assign dec_valid_o = out_v;
  assign dec_data_o  = out_data;
  assign dec_sec_o   = out_sec;
  assign dec_ded_o   = out_ded;
endmodule

module secded_codec_chk #(
  parameter int K = 4,
  parameter int R = 4,
  localparam int N = K + R
) (
  input logic         clk,
  input logic         rst_n,
  input logic [K-1:0] enc_data_i,
  input logic [N-1:0] enc_code_o,
  input logic         dec_valid_i,
  input logic         dec_ready_o,
  input logic [N-1:0] dec_code_i,
  input logic         dec_valid_o,
  input logic         dec_ready_i,
  input logic [K-1:0] dec_data_o,
  input logic         dec_sec_o,
  input logic         dec_ded_o
);
  p_flags_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid_o |-> !(dec_sec_o && dec_ded_o));

  p_hold_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid_o && !dec_ready_i) |=> (dec_valid_o && $stable(dec_data_o)
                                       && $stable(dec_sec_o) && $stable(dec_ded_o)));

  p_accept_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid_i && dec_ready_o) |=> dec_valid_o);

  p_clean_roundtrip_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid_i && dec_ready_o && dec_code_i == enc_code_o)
      |=> (!dec_sec_o && !dec_ded_o && dec_data_o == $past(enc_data_i)));

  p_reset_idle_r9: assert property (@(posedge clk)
    !rst_n |=> !dec_valid_o);
endmodule

bind secded_codec secded_codec_chk #(.K(K), .R(R)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .enc_data_i  (enc_data_i),
  .enc_code_o  (enc_code_o),
  .dec_valid_i (dec_valid_i),
  .dec_ready_o (dec_ready_o),
  .dec_code_i  (dec_code_i),
  .dec_valid_o (dec_valid_o),
  .dec_ready_i (dec_ready_i),
  .dec_data_o  (dec_data_o),
  .dec_sec_o   (dec_sec_o),
  .dec_ded_o   (dec_ded_o)
);

// File: tb/secded_codec_tb.sv
`timescale 1ns/1ps
module secded_codec_tb;
  localparam int K = 4;
  localparam int R = 4;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [K-1:0] enc_data_i = '0;
  logic [N-1:0] enc_code_o;
  logic         dec_valid_i = 1'b0;
  logic         dec_ready_o;
  logic [N-1:0] dec_code_i = '0;
  logic         dec_valid_o;
  logic         dec_ready_i = 1'b1;
  logic [K-1:0] dec_data_o;
  logic         dec_sec_o;
  logic         dec_ded_o;

  always #2.5 clk = ~clk;

  secded_codec #(.K(K), .R(R)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .enc_data_i(enc_data_i), .enc_code_o(enc_code_o),
    .dec_valid_i(dec_valid_i), .dec_ready_o(dec_ready_o), .dec_code_i(dec_code_i),
    .dec_valid_o(dec_valid_o), .dec_ready_i(dec_ready_i),
    .dec_data_o(dec_data_o), .dec_sec_o(dec_sec_o), .dec_ded_o(dec_ded_o)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct packed {
    logic [K-1:0] d;
    logic         s;
    logic         e;
    logic [7:0]   tag;
  } exp_t;

  exp_t q[$];

  task automatic note(bit ok, string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s", msg);
    end
  endtask

  // R1 check-bit formulas
  function automatic logic [R-1:0] ref_chk(logic [K-1:0] d);
    logic [R-1:0] c;
    c[0] = d[0] ^ d[1] ^ d[2];
    c[1] = d[0] ^ d[1] ^ d[3];
    c[2] = d[0] ^ d[2] ^ d[3];
    c[3] = d[1] ^ d[2] ^ d[3];
    return c;
  endfunction

  function automatic logic [N-1:0] ref_code(logic [K-1:0] d);
    return {ref_chk(d), d};
  endfunction

  // Driver: call at posedge+1
  task automatic send(logic [N-1:0] code, logic [K-1:0] ed, bit es, bit ee, logic [7:0] tag);
    exp_t x;
    dec_code_i  = code;
    dec_valid_i = 1'b1;
    forever begin
      @(negedge clk);
      if (dec_ready_o) break;
    end
    x.d = ed; x.s = es; x.e = ee; x.tag = tag;
    q.push_back(x);
    @(posedge clk);
    #1;
    dec_valid_i = 1'b0;
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && dec_valid_o && dec_ready_i) begin
      if (q.size() == 0) begin
        note(1'b0, $sformatf("R7 unexpected output actual=%h expected=none", dec_data_o));
      end else begin
        exp_t x;
        string req;
        x = q.pop_front();
        req = (x.tag == 8'd2) ? "R2" : (x.tag == 8'd3) ? "R3" :
              (x.tag == 8'd4) ? "R4" : (x.tag == 8'd5) ? "R5" : "R8";
        note({dec_data_o, dec_sec_o, dec_ded_o} == {x.d, x.s, x.e},
             $sformatf("%s decode actual data=%h sec=%0b ded=%0b expected data=%h sec=%0b ded=%0b",
                       req, dec_data_o, dec_sec_o, dec_ded_o, x.d, x.s, x.e));
        note(!(dec_sec_o && dec_ded_o),
             $sformatf("R6 flags actual sec=%0b ded=%0b expected not both", dec_sec_o, dec_ded_o));
      end
    end
  end

  bit       toggle_en = 1'b0;
  logic [7:0] lfsr = 8'hA5;

  initial begin : toggler
    forever begin
      @(posedge clk);
      #1;
      if (toggle_en) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        dec_ready_i = lfsr[0] | lfsr[3];
      end
    end
  end

  initial begin : watchdog
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R9 reset state
    note(dec_valid_o == 1'b0, $sformatf("R9 reset valid actual=%0b expected=0", dec_valid_o));
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    note(dec_valid_o == 1'b0, $sformatf("R9 after reset valid actual=%0b expected=0", dec_valid_o));
    note(dec_ready_o == 1'b1, $sformatf("R7 idle ready actual=%0b expected=1", dec_ready_o));

    // R1 encoder table
    for (int d = 0; d < 16; d++) begin
      enc_data_i = 4'(d);
      #1;
      note(enc_code_o == ref_code(4'(d)),
           $sformatf("R1 encode d=%h actual=%h expected=%h", d, enc_code_o, ref_code(4'(d))));
    end

    @(posedge clk); #1;
    // R7 timing
    send(ref_code(4'h9), 4'h9, 1'b0, 1'b0, 8'd2);
    @(negedge clk);
    note(dec_valid_o == 1'b1, $sformatf("R7 valid after accept actual=%0b expected=1", dec_valid_o));
    @(negedge clk);
    note(dec_valid_o == 1'b0, $sformatf("R7 valid drops actual=%0b expected=0", dec_valid_o));

    // R8 stall
    @(posedge clk); #1;
    dec_ready_i = 1'b0;
    send(ref_code(4'h6) ^ 8'h04, 4'h6, 1'b1, 1'b0, 8'd8);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      note(dec_valid_o && dec_data_o == 4'h6 && dec_sec_o && !dec_ded_o,
           $sformatf("R8 stalled hold actual v=%0b d=%h s=%0b e=%0b expected v=1 d=6 s=1 e=0",
                     dec_valid_o, dec_data_o, dec_sec_o, dec_ded_o));
      note(dec_ready_o == 1'b0, $sformatf("R7 ready while stalled actual=%0b expected=0", dec_ready_o));
    end
    @(posedge clk); #1;
    dec_ready_i = 1'b1;
    repeat (2) @(posedge clk);
    #1;

    // R2 clean, R3 data flips, R4 check flips
    for (int d = 0; d < 16; d++) begin
      send(ref_code(4'(d)), 4'(d), 1'b0, 1'b0, 8'd2);
      for (int b = 0; b < N; b++) begin
        if (b < K)
          send(ref_code(4'(d)) ^ (8'd1 << b), 4'(d), 1'b1, 1'b0, 8'd3);
        else
          send(ref_code(4'(d)) ^ (8'd1 << b), 4'(d), 1'b1, 1'b0, 8'd4);
      end
    end

    // R5 double errors under irregular back-pressure
    toggle_en = 1'b1;
    for (int d = 0; d < 16; d += 5) begin
      for (int a = 0; a < N; a++) begin
        for (int b = a + 1; b < N; b++) begin
          logic [N-1:0] cw;
          cw = ref_code(4'(d)) ^ (8'd1 << a) ^ (8'd1 << b);
          send(cw, cw[K-1:0], 1'b0, 1'b1, 8'd5);
        end
      end
    end
    toggle_en = 1'b0;
    @(posedge clk); #1;
    dec_ready_i = 1'b1;

    repeat (20) @(negedge clk);
    note(q.size() == 0, $sformatf("R7 drain actual=%0d expected=0", q.size()));
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule